// File: doc/BRIEF.md
# BCD Timekeeping Register Bank

This block keeps time of day and a calendar in packed BCD counters that advance on a single-cycle 1 Hz tick. Software does not see the counters directly. It sees eight byte-wide user registers at the top eight addresses of a byte address space. These registers are a copy of the counters. The copy is refreshed in the clock cycle after each counted second, and every field changes in that same cycle.

The lowest of the eight addresses is a control byte with two freeze bits. The read-freeze bit stops the refresh, so software can read a coherent timestamp one byte at a time. The set-freeze bit also stops the refresh. While it is 1, software writes new time values into the user registers. Clearing it loads all of those values into the counters at once.

The seconds byte also holds an oscillator stop bit, which comes out of reset set. The day byte holds a century enable bit and a century flag. When the enable bit is 1, the flag inverts each time the year wraps.

Top module: `rtc_bank`

## Requirements
- R1: After reset the user registers read: control 0x00, seconds 0x80 (stop bit set), minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01, year 0x00. The counters hold the same time.
- R2: The registers respond only when `cs` is high and every address bit above bit 2 is 1. Address bits 2:0 select the byte: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. Any other access reads 0x00 and a write there changes nothing.
- R3: Unused bits are not stored and read 0. Used bits per offset: control 7:0, seconds 7:0, minutes 6:0, hours 5:0, day 6:4 and 2:0, date 7:0, month 4:0, year 7:0.
- R4: A tick advances the counters by one second only while seconds bit 7 (stop) is 0. Seconds and minutes wrap 59 to 00, hours wrap 23 to 00, and the day of week (bits 2:0) wraps 7 to 1 on each midnight.
- R5: The date wraps to 01 after the last day of its month. April, June, September and November have 30 days, and February has 29 days when the year is divisible by 4, otherwise 28. The month wraps 12 to 01, and the year wraps 99 to 00.
- R6: On the 99 to 00 year wrap, day bit 4 (century flag) inverts if day bit 5 (century enable) is 1 and holds otherwise.
- R7: If neither freeze bit is set, every time field of the user registers takes the counter value in the cycle after a counted tick, all fields in the same cycle. Stop, century enable, frequency-test enable (day bit 6) and battery-low enable (date bit 7) are not refreshed.
- R8: While control bit 6 (read freeze) is 1, the user registers are not refreshed but still accept bus writes. The first counted tick after the bit clears refreshes them again.
- R9: Control bit 7 (set freeze) also blocks the refresh. A control write that clears it while it is 1 loads the user time fields into the counters at that edge. A tick in the same cycle is not counted.
- R10: When a bus write and a refresh fall in the same cycle, the written byte takes the bus data. The other bytes take the refreshed values.
- R11: Date bit 6 reads 1 only when date bit 7 (battery-low enable) is 1 and input `batt_low` is high. Writes to bit 6 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| cs | input | 1 | Bus select |
| we | input | 1 | Bus write strobe (with cs) |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the registers |
| batt_low | input | 1 | Battery-low condition from outside |

## Verification
Two collisions matter here. The first is a bus write landing in the cycle when a refresh is pending. The bench provokes it by writing the minutes byte in the cycle right after a counted tick. It then expects the written value in that byte and fresh counter values in every other byte. The second is the set-freeze release coinciding with a tick. The bench clears the set-freeze bit in the tick cycle and expects the loaded time to stand unchanged until the following tick. A behavioural model keeps binary time and is compared with the read data on every cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NREGS = 8;
  localparam logic [2:0] OFF_CTRL = 3'd0;
  localparam logic [2:0] OFF_SEC  = 3'd1;
  localparam logic [2:0] OFF_MIN  = 3'd2;
  localparam logic [2:0] OFF_HR   = 3'd3;
  localparam logic [2:0] OFF_DAY  = 3'd4;
  localparam logic [2:0] OFF_DATE = 3'd5;
  localparam logic [2:0] OFF_MON  = 3'd6;
  localparam logic [2:0] OFF_YR   = 3'd7;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [2:0] dow;
    logic       cb;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam rtc_time_t TIME_RST = '{yr: 8'h00, mon: 8'h01, date: 8'h01, dow: 3'd1,
                                     cb: 1'b0, hr: 8'h00, min: 8'h00, sec: 8'h00};

  // storable bits per register offset
  function automatic logic [7:0] store_mask(input logic [2:0] off);
    case (off)
      OFF_MIN:  return 8'h7F;
      OFF_HR:   return 8'h3F;
      OFF_DAY:  return 8'h77;
      OFF_DATE: return 8'hBF;
      OFF_MON:  return 8'h1F;
      default:  return 8'hFF;
    endcase
  endfunction

  function automatic logic [6:0] bcd2bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic [6:0] yb;
    yb = bcd2bin(yr);
    case (mon)
      8'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_time_t next_time(input rtc_time_t t, input logic ceb);
    rtc_time_t n;
    n = t;
    if (t.sec != 8'h59) n.sec = bcd_inc(t.sec);
    else begin
      n.sec = 8'h00;
      if (t.min != 8'h59) n.min = bcd_inc(t.min);
      else begin
        n.min = 8'h00;
        if (t.hr != 8'h23) n.hr = bcd_inc(t.hr);
        else begin
          n.hr  = 8'h00;
          n.dow = (t.dow == 3'd7) ? 3'd1 : t.dow + 3'd1;
          if (t.date != month_len(t.mon, t.yr)) n.date = bcd_inc(t.date);
          else begin
            n.date = 8'h01;
            if (t.mon != 8'h12) n.mon = bcd_inc(t.mon);
            else begin
              n.mon = 8'h01;
              if (t.yr != 8'h99) n.yr = bcd_inc(t.yr);
              else begin
                n.yr = 8'h00;
                n.cb = t.cb ^ ceb;
              end
            end
          end
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_counters.sv
module rtc_counters
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      stop,
  input  logic      ceb,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t cnt,
  output logic      adv
);

  logic adv_now;
  logic year_wrap;

  assign adv_now   = tick && !stop && !load;
  assign year_wrap = (cnt.yr == 8'h99) && (cnt.mon == 8'h12) && (cnt.date == 8'h31) &&
                     (cnt.hr == 8'h23) && (cnt.min == 8'h59) && (cnt.sec == 8'h59);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= TIME_RST;
      adv <= 1'b0;
    end else begin
      adv <= adv_now;
      if (load)         cnt <= load_val;
      else if (adv_now) cnt <= next_time(cnt, ceb);
    end
  end

  // R4: stopped and not loading means the time holds
  p_stop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !load) |=> $stable(cnt));

  // R9: a load copies the user fields exactly
  p_load_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));

  // R6: century flag follows the enable on the year wrap
  p_century_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_now && year_wrap) |=> (cnt.cb == ($past(cnt.cb) ^ $past(ceb))));

endmodule

// File: rtl/rtc_user_regs.sv
module rtc_user_regs
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              batt_low,
  input  rtc_time_t         cnt,
  input  logic              adv,
  output rtc_time_t         user_time,
  output logic              stop,
  output logic              ceb,
  output logic              load
);

  localparam int HI_W = ADDR_W - 3;

  logic [7:0] ureg [NREGS];
  logic       hit;
  logic [2:0] off;
  logic       bus_wr;
  logic       refresh;
  logic       frozen;
  logic [7:0] rd_raw;

  assign hit     = cs && (addr[ADDR_W-1:3] == {HI_W{1'b1}});
  assign off     = addr[2:0];
  assign bus_wr  = hit && we;
  assign frozen  = ureg[OFF_CTRL][7] || ureg[OFF_CTRL][6];
  assign refresh = adv && !frozen;
  assign load    = bus_wr && (off == OFF_CTRL) && !wdata[7] && ureg[OFF_CTRL][7];

  assign stop = ureg[OFF_SEC][7];
  assign ceb  = ureg[OFF_DAY][5];

  assign user_time = '{yr: ureg[OFF_YR], mon: ureg[OFF_MON], date: {2'b00, ureg[OFF_DATE][5:0]},
                       dow: ureg[OFF_DAY][2:0], cb: ureg[OFF_DAY][4], hr: ureg[OFF_HR],
                       min: ureg[OFF_MIN], sec: {1'b0, ureg[OFF_SEC][6:0]}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ureg[OFF_CTRL] <= 8'h00;
      ureg[OFF_SEC]  <= 8'h80;
      ureg[OFF_MIN]  <= 8'h00;
      ureg[OFF_HR]   <= 8'h00;
      ureg[OFF_DAY]  <= 8'h01;
      ureg[OFF_DATE] <= 8'h01;
      ureg[OFF_MON]  <= 8'h01;
      ureg[OFF_YR]   <= 8'h00;
    end else begin
      if (refresh) begin
        ureg[OFF_YR]        <= cnt.yr;
        ureg[OFF_MON]       <= cnt.mon;
        ureg[OFF_DATE][5:0] <= cnt.date[5:0];
        ureg[OFF_DAY][4]    <= cnt.cb;
        ureg[OFF_DAY][2:0]  <= cnt.dow;
        ureg[OFF_HR]        <= cnt.hr;
        ureg[OFF_MIN]       <= cnt.min;
        ureg[OFF_SEC][6:0]  <= cnt.sec[6:0];
      end
      if (bus_wr) ureg[off] <= wdata & store_mask(off);
    end
  end

  always_comb begin
    rd_raw = ureg[off];
    if (off == OFF_DATE) rd_raw[6] = ureg[OFF_DATE][7] && batt_low;
    rdata = hit ? rd_raw : 8'h00;
  end

  // R8: a frozen bank changes only through the bus
  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !bus_wr) |=> $stable(user_time));

  // R7: a refresh copies every counter field together
  p_refresh_whole_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && !bus_wr) |=> (user_time == $past(cnt)));

  // R3: bits outside the map never read as 1
  p_unused_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((rdata & ~(store_mask(off) | ((off == OFF_DATE) ? 8'h40 : 8'h00))) == 8'h00));

  // R2: unselected accesses read zero
  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (rdata == 8'h00));

endmodule

// File: rtl/rtc_bank.sv
module rtc_bank
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              batt_low
);

  rtc_time_t cnt;
  rtc_time_t user_time;
  logic      adv;
  logic      stop;
  logic      ceb;
  logic      load;

  rtc_counters u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_1hz),
    .stop     (stop),
    .ceb      (ceb),
    .load     (load),
    .load_val (user_time),
    .cnt      (cnt),
    .adv      (adv)
  );

  rtc_user_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .we        (we),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .batt_low  (batt_low),
    .cnt       (cnt),
    .adv       (adv),
    .user_time (user_time),
    .stop      (stop),
    .ceb       (ceb),
    .load      (load)
  );

endmodule

// File: tb/tb_rtc_bank.sv
module tb_rtc_bank;

  localparam int AW = 13;
  localparam logic [AW-1:0] TOP = 13'h1FF8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_1hz = 1'b0;
  logic          cs = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          batt_low = 1'b0;

  int checks = 0;
  int failures = 0;
  string cur = "R1";

  // behavioural model: binary time, byte image of the user bank
  int s, mi, h, dw, dt, mo, y, cb;
  int u [8];
  bit pend;
  int rot = 0;

  rtc_bank #(.ADDR_W(AW)) dut (.*);

  always #10 clk = ~clk;

  function automatic int mask_of(int off);
    case (off)
      2: return 'h7F; 3: return 'h3F; 4: return 'h77;
      5: return 'hBF; 6: return 'h1F; default: return 'hFF;
    endcase
  endfunction

  function automatic int tobcd(int x); return (x / 10) * 16 + x % 10; endfunction
  function automatic int frombcd(int x); return (x / 16) * 10 + x % 16; endfunction

  function automatic int days_in(int m, int yy);
    if (m == 2) return (yy % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic bit is_top(logic [AW-1:0] a); return a[AW-1:3] == '1; endfunction

  function automatic int model_read(bit c, logic [AW-1:0] a);
    int off;
    int v;
    if (!c || !is_top(a)) return 0;
    off = int'(a[2:0]);
    v = u[off];
    if (off == 5 && ((u[5] & 'h80) != 0) && batt_low) v = v | 'h40;
    return v;
  endfunction

  task automatic model_reset();
    s = 0; mi = 0; h = 0; dw = 1; dt = 1; mo = 1; y = 0; cb = 0; pend = 0;
    u[0] = 'h00; u[1] = 'h80; u[2] = 0; u[3] = 0; u[4] = 1; u[5] = 1; u[6] = 1; u[7] = 0;
  endtask

  task automatic model_edge(bit c, bit w, logic [AW-1:0] a, int d, bit t);
    int os, omi, oh, odw, odt, omo, oy, ocb, off;
    bit wr, ld, rf, stp, ceb;
    os = s; omi = mi; oh = h; odw = dw; odt = dt; omo = mo; oy = y; ocb = cb;
    off = int'(a[2:0]);
    wr = c && w && is_top(a);
    stp = (u[1] & 'h80) != 0;
    ceb = (u[4] & 'h20) != 0;
    ld = wr && off == 0 && ((d & 'h80) == 0) && ((u[0] & 'h80) != 0);
    rf = pend && ((u[0] & 'hC0) == 0);
    pend = t && !stp && !ld;
    if (ld) begin
      s = frombcd(u[1] & 'h7F); mi = frombcd(u[2]); h = frombcd(u[3]); dw = u[4] & 7;
      cb = (u[4] >> 4) & 1; dt = frombcd(u[5] & 'h3F); mo = frombcd(u[6]); y = frombcd(u[7]);
    end else if (t && !stp) begin
      s++;
      if (s == 60) begin s = 0; mi++; end
      if (mi == 60) begin mi = 0; h++; end
      if (h == 24) begin
        h = 0; dw = (dw == 7) ? 1 : dw + 1; dt++;
        if (dt > days_in(mo, y)) begin
          dt = 1; mo++;
          if (mo > 12) begin
            mo = 1; y++;
            if (y > 99) begin y = 0; if (ceb) cb = cb ^ 1; end
          end
        end
      end
    end
    if (rf) begin
      u[7] = tobcd(oy); u[6] = tobcd(omo); u[5] = (u[5] & 'h80) | tobcd(odt);
      u[4] = (u[4] & 'h60) | (ocb << 4) | odw; u[3] = tobcd(oh); u[2] = tobcd(omi);
      u[1] = (u[1] & 'h80) | tobcd(os);
    end
    if (wr) u[off] = d & mask_of(off);
  endtask

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s addr=%h got=%h exp=%h at %0t", req, addr, got, exp, $time);
    end
  endtask

  task automatic step(bit c, bit w, logic [AW-1:0] a, int d, bit t);
    cs = c; we = w; addr = a; wdata = 8'(d); tick_1hz = t;
    #1;
    check(cur, int'(rdata), model_read(c, a));
    @(posedge clk);
    model_edge(c, w, a, d, t);
    @(negedge clk);
  endtask

  task automatic wr(int off, int d); step(1, 1, TOP + AW'(off), d, 0); endtask
  task automatic rd(int off); step(1, 0, TOP + AW'(off), 0, 0); endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      step(1, 0, TOP + AW'(rot % 8), 0, 1);
      rot++;
      for (int g = 0; g < gap; g++) begin
        step(1, 0, TOP + AW'(rot % 8), 0, 0);
        rot++;
      end
    end
  endtask

  task automatic read_all(); for (int k = 0; k < 8; k++) rd(k); endtask

  // loads a full time through the set-freeze bit
  task automatic set_time(int yy, int mm, int dd, int dayb, int hh, int mn, int ss);
    wr(0, 'h80);
    wr(7, yy); wr(6, mm); wr(5, dd); wr(4, dayb); wr(3, hh); wr(2, mn); wr(1, ss);
    wr(0, 'h00);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    // R1: reset image of all eight bytes
    cur = "R1"; read_all();
    // R2: unselected and out-of-window accesses
    cur = "R2";
    step(0, 0, TOP + 13'd1, 0, 0);
    step(1, 1, 13'h0005, 'hAA, 0); step(1, 0, 13'h0005, 0, 0);
    step(1, 1, 13'h1FF0, 'h55, 0); read_all();
    // R4: stopped clock ignores ticks
    cur = "R4"; ticks(3, 1); read_all();
    // R3: unused bits dropped
    cur = "R3"; wr(6, 'hFF); rd(6); wr(2, 'hFF); rd(2); wr(3, 'hFF); rd(3); wr(4, 'hFF); rd(4);
    set_time('h00, 'h01, 'h01, 'h01, 'h00, 'h00, 'h00);
    // R4: run seconds, minutes, hours and day-of-week wraps
    cur = "R4"; ticks(70, 1);
    set_time('h10, 'h05, 'h10, 'h07, 'h23, 'h59, 'h58); ticks(4, 2); read_all();
    // R5: month lengths and leap years
    cur = "R5";
    set_time('h04, 'h02, 'h28, 'h03, 'h23, 'h59, 'h59); ticks(2, 1); read_all();
    set_time('h05, 'h02, 'h28, 'h03, 'h23, 'h59, 'h59); ticks(2, 1); read_all();
    set_time('h05, 'h04, 'h30, 'h03, 'h23, 'h59, 'h59); ticks(2, 1); read_all();
    set_time('h05, 'h12, 'h31, 'h03, 'h23, 'h59, 'h59); ticks(2, 1); read_all();
    // R6: century flag with enable on, then off
    cur = "R6";
    set_time('h99, 'h12, 'h31, 'h25, 'h23, 'h59, 'h59); ticks(2, 1); read_all();
    set_time('h99, 'h12, 'h31, 'h15, 'h23, 'h59, 'h59); ticks(2, 1); read_all();
    set_time('h99, 'h12, 'h31, 'h05, 'h23, 'h59, 'h59); ticks(2, 1); read_all();
    // R7: refresh after counted ticks
    cur = "R7"; ticks(5, 0); read_all();
    // R8: read freeze, writes accepted while frozen, resume
    cur = "R8";
    wr(0, 'h40); ticks(4, 1); wr(2, 'h33); read_all(); ticks(2, 0);
    wr(0, 'h00); read_all(); ticks(2, 1); read_all();
    // R9: load with a same-cycle tick
    cur = "R9";
    wr(0, 'h80); wr(3, 'h12); wr(2, 'h34); wr(1, 'h56);
    step(1, 1, TOP, 'h00, 1); read_all(); ticks(1, 1); read_all();
    // R10: bus write in the refresh cycle
    cur = "R10";
    ticks(1, 0); wr(2, 'h45); read_all(); ticks(1, 0); wr(7, 'h77); read_all();
    // R11: battery-low flag
    cur = "R11";
    wr(5, 'hC1); rd(5); batt_low = 1'b1; rd(5); wr(5, 'h41); rd(5); wr(5, 'h81); rd(5);
    batt_low = 1'b0; rd(5);
    // R4: stop again and confirm the time holds
    cur = "R4"; wr(1, 'h80); ticks(3, 1); read_all();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule